// File: doc/BRIEF.md
# Edge-Timed Clock Delay

This block regenerates a slow, asynchronous input clock on an output pin, shifted later in time by a programmable number of fast-clock cycles. It does not sample the input into a long shift register. Instead, it brings the input into the fast clock domain and detects its edges there. Each rising edge starts a rising-edge timer, and each falling edge starts a separate falling-edge timer. When a timer expires, it sets or clears a registered output. Edge placement on the output is therefore exact to one fast-clock period.

The delay is given in fast-clock cycles and is measured from the first fast-clock edge that samples the new input level. With a 100 MHz timing clock, a setting of 300 gives about 3 µs. The fixed latency of the synchroniser and the edge detector is part of the delay and is subtracted inside the block. The input must keep both its high and low phases longer than the delay. That way, at most one edge of each polarity is in flight. If a second edge of the same polarity arrives early, the block restarts that timer and raises a sticky overrun flag.

Top module: `cdly_top`

## Requirements
- R1: While reset is asserted and after its release, `clk_out` and `overrun` are 0 until an input edge has been timed out.
- R2: A rising input transition makes `clk_out` go high exactly D fast-clock cycles after the first clock edge that samples the new level, where D is the delay setting and D is at least 3.
- R3: A falling input transition makes `clk_out` go low exactly D cycles after the first clock edge that samples the new level.
- R4: Delay settings below 3 (0, 1, 2) act as 3, because 3 cycles is the synchroniser and edge-detector latency.
- R5: `delay_cnt` is captured only while neither timer is running. A change made while a timer runs has no effect on the edges already in flight or on edges launched before both timers go idle.
- R6: An edge of one polarity that arrives while the timer of that polarity is still running restarts that timer from the new edge and sets `overrun`. `overrun` stays 1 until reset.
- R7: The two timers run independently. A high pulse of W cycles, with W shorter than D, appears on `clk_out` as a high pulse of W cycles starting D cycles after the rising edge.
- R8: `clk_out` changes only in the cycle after a timer expires. If both timers expire together, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in | input | 1 | Slow clock to be delayed, asynchronous to `clk` |
| delay_cnt | input | CNT_W (16) | Delay in `clk` cycles, taken while both timers are idle |
| clk_out | output | 1 | Delayed copy of `clk_in`, registered |
| overrun | output | 1 | Sticky flag: an edge arrived while its timer was still running |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a two-stage synchroniser, which gives a minimum delay of 3 cycles. Delay settings of 0, 3, 20 and 300 take in the clamp, the minimum-latency path and the nominal 300-cycle case. Pulses narrower than the delay put both timers in flight at once. A rise-fall-rise burst inside one delay window restarts the rising timer while the falling timer still runs.

// File: rtl/cdly_pkg.sv
package cdly_pkg;
  // Reload value of a timer: programmed delay minus the fixed front-end latency,
  // clamped so that any setting at or below the latency gives the minimum delay.
  function automatic int unsigned reload_of(int unsigned dly, int unsigned lat);
    return (dly > lat) ? (dly - lat) : 0;
  endfunction
endpackage

// File: rtl/cdly_sync.sv
module cdly_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synced value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise_ev =  sh[STAGES-1] & ~sh[STAGES];
  assign fall_ev = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/cdly_timer.sv
module cdly_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             fire,
  output logic             restart
);
  logic [CNT_W-1:0] cnt;

  assign fire    = busy && (cnt == '0);
  assign restart = start && busy && !fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cdly_top.sv
module cdly_top #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_in,
  input  logic [CNT_W-1:0] delay_cnt,
  output logic             clk_out,
  output logic             overrun
);
  import cdly_pkg::*;

  // synchroniser stages plus the edge-detect register
  localparam int LAT = SYNC_STAGES + 1;

  logic             rise_ev, fall_ev;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] reload;
  logic [1:0]       start, busy, fire, restart;   // index 0: rising, 1: falling

  cdly_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(clk_in),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  // delay setting is taken only while nothing is in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dly_q <= '0;
    else if (busy == 2'b00)         dly_q <= delay_cnt;
  end

  assign reload = CNT_W'(reload_of(int'(dly_q), LAT));
  assign start  = {fall_ev, rise_ev};

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    cdly_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start[g]),
      .load_val(reload),
      .busy    (busy[g]),
      .fire    (fire[g]),
      .restart (restart[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_out <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (fire[1])      clk_out <= 1'b0;
      else if (fire[0]) clk_out <= 1'b1;
      if (|restart)     overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/cdly_check.sv
module cdly_check (
  input logic clk,
  input logic rst_n,
  input logic clk_out,
  input logic overrun,
  input logic rise_ev,
  input logic fall_ev,
  input logic [1:0] busy,
  input logic [1:0] fire
);
  // R1: reset forces the output low
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !clk_out);

  // R2: rising timer expiry sets the output
  p_set_on_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[0] && !fire[1]) |=> clk_out);

  // R3: falling timer expiry clears the output
  p_clr_on_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire[1] |=> !clk_out);

  // R6: overrun is sticky
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R7: each detected edge launches its own timer
  p_rise_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> busy[0]);
  p_fall_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> busy[1]);

  // R8: no output change without a timer expiry
  p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == 2'b00) |=> $stable(clk_out));
endmodule

bind cdly_top cdly_check u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clk_out(clk_out),
  .overrun(overrun),
  .rise_ev(rise_ev),
  .fall_ev(fall_ev),
  .busy   (busy),
  .fire   (fire)
);

// File: tb/tb_cdly_top.sv
module tb_cdly_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_in = 1'b0;
  logic [15:0] delay_cnt = 16'd20;
  logic        clk_out, overrun;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdly_top dut (
    .clk(clk), .rst_n(rst_n), .clk_in(clk_in),
    .delay_cnt(delay_cnt), .clk_out(clk_out), .overrun(overrun)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // drive input at a negedge, return posedge count at that moment
  task automatic drive(input logic v, output int c0);
    @(negedge clk);
    clk_in = v;
    c0 = cyc;
  endtask

  // output must hold old value through edge c0+D and show new after c0+D+1
  task automatic expect_edge(input string req, input int c0, input int d, input logic nv);
    wait_to(c0 + d);
    chk(req, clk_out, ~nv);
    wait_to(c0 + d + 1);
    chk(req, clk_out, nv);
  endtask

  task automatic t_reset;
    chk("R1", clk_out, 1'b0);
    chk("R1", overrun, 1'b0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1", clk_out, 1'b0);
    chk("R1", overrun, 1'b0);
  endtask

  task automatic t_basic(input int d);
    int c0;
    delay_cnt = 16'(d);
    repeat (4) @(negedge clk);
    drive(1'b1, c0);
    expect_edge("R2", c0, d, 1'b1);
    repeat (d + 5) @(negedge clk);
    drive(1'b0, c0);
    expect_edge("R3", c0, d, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_clamp;
    int c0;
    delay_cnt = 16'd0;
    repeat (4) @(negedge clk);
    drive(1'b1, c0);
    expect_edge("R4", c0, 3, 1'b1);
    repeat (6) @(negedge clk);
    drive(1'b0, c0);
    expect_edge("R4", c0, 3, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_delay_hold;
    int c0, c1;
    delay_cnt = 16'd40;
    repeat (4) @(negedge clk);
    drive(1'b1, c0);
    repeat (5) @(negedge clk);
    delay_cnt = 16'd10;          // ignored: rising timer running
    repeat (10) @(negedge clk);
    drive(1'b0, c1);             // launched before idle: still uses 40
    expect_edge("R5", c0, 40, 1'b1);
    expect_edge("R5", c1, 40, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_pulse;
    int c0, c1;
    delay_cnt = 16'd300;
    repeat (4) @(negedge clk);
    drive(1'b1, c0);
    repeat (99) @(negedge clk);
    drive(1'b0, c1);
    chk("R7", 1'(c1 - c0 == 100), 1'b1);
    expect_edge("R7", c0, 300, 1'b1);
    expect_edge("R7", c1, 300, 1'b0);
    chk("R6", overrun, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_overrun;
    int c0, c1, c2;
    delay_cnt = 16'd300;
    repeat (4) @(negedge clk);
    drive(1'b1, c0);
    repeat (49) @(negedge clk);
    drive(1'b0, c1);
    repeat (49) @(negedge clk);
    drive(1'b1, c2);
    repeat (4) @(negedge clk);
    chk("R6", overrun, 1'b1);
    // first rise was superseded: still low where it would have fired
    wait_to(c0 + 301);
    chk("R6", clk_out, 1'b0);
    wait_to(c1 + 301);
    chk("R8", clk_out, 1'b0);
    expect_edge("R6", c2, 300, 1'b1);
    repeat (20) @(negedge clk);
    chk("R6", overrun, 1'b1);
    chk("R8", clk_out, 1'b1);
  endtask

  initial begin : wd
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic(20);
    t_basic(300);
    t_basic(3);
    t_clamp();
    t_delay_hold();
    t_pulse();
    t_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule